// File: doc/BRIEF.md
# Bus-Mapped Successive-Approximation Conversion Controller

This block is the digital control of an 8-bit successive-approximation converter that a processor addresses as one memory location. The host drives only an active-low chip select and an active-low read strobe. Every operation comes from the order of their levels and edges: starting a conversion, reading the result and re-arming the converter. No start or read register exists. The block sends its trial code to an external DAC and takes a one-bit comparator decision back. It drives an active-low busy flag that is high whenever the converter is idle or finished, and it puts the result on an 8-bit data output qualified by an output enable.

How the host wires the strobes decides the access style, and the logic does not change. A host with separate write and read cycles starts a conversion with a write, waits, then reads. A host with chip select tied low reads, and the rising read edge restarts the converter. A wait-state host ties both strobes together and holds its ready input on the busy flag, so a single read starts, waits and returns data. Both strobes are asynchronous and pass through synchronizers. Each approximation step advances on a single-cycle conversion clock enable. At power-up the block sits in the finished state with meaningless data, so the first access must be a dummy read.

Top module: `sar_bus_ctrl`

## Requirements
- R1: After reset, busy_n is 1 and data_oe is 0. The block is in the finished state, so a read with cs_n and rd_n both low asserts data_oe.
- R2: In the idle (re-armed) state, cs_n low starts a conversion and busy_n goes low. This holds with rd_n high and with rd_n low at the same time as cs_n. A strobe edge reaches the control logic after two clk edges, and busy_n falls on the third edge.
- R3: The conversion is a binary search starting at the MSB. A trial bit is cleared when cmp_above is 1 (the DAC code is above the input) and kept otherwise, and then the next lower bit is set. With cmp_above = (trial_code > input), the result equals the input code.
- R4: A conversion takes exactly WIDTH asserted conv_en cycles. busy_n goes high only after the LSB decision. With conv_en held at 1, busy_n is high on the eleventh clk edge after cs_n falls. When conv_en is 0, the conversion holds.
- R5: During a conversion, toggling cs_n has no effect on its result or its length.
- R6: data_oe is 1 only while the synchronized cs_n and rd_n are both low and busy_n is 1. data_o is all zeros whenever data_oe is 0.
- R7: A 0-to-1 edge of rd_n while cs_n is low resets the converter. The reset completes on the next conv_en cycle and loads trial_code with 8'h80. The reset also applies when cs_n rises together with rd_n. A rd_n pulse while cs_n is high has no effect, and the stored result remains readable.
- R8: If cs_n is still low when a reset completes, a new conversion starts automatically.
- R9: In the finished state, cs_n low with rd_n high does not start a conversion. busy_n stays 1 and the result is kept.
- R10: A read while busy_n is 0 keeps data_oe at 0 and does not alter the conversion. A rd_n rising edge during a conversion is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Asynchronous active-low chip select |
| rd_n | input | 1 | Asynchronous active-low read strobe |
| conv_en | input | 1 | Single-cycle conversion clock enable |
| cmp_above | input | 1 | Comparator decision: 1 when the DAC code is above the analog input |
| trial_code | output | WIDTH | Current trial code to the DAC |
| busy_n | output | 1 | Active-low busy: 0 while a conversion runs |
| data_o | output | WIDTH | Conversion result, zero when not enabled |
| data_oe | output | 1 | Data output enable |

## Verification
The binary search is exercised with input codes 0x00, 0xFF, 0x80, 0x7F, 0x01, 0xAA, 0x55 and 0xC8. The two extremes show whether every bit is cleared or every bit is kept, and the codes on either side of 0x80 separate the MSB decision from the lower bits. The alternating patterns catch a shifted or skipped bit pointer. The same search then runs under write-then-read access, tied-low chip select and tied-together strobes. Those three runs separate a correct reset-and-restart sequence from one that drops the reset, restarts from the finished state or misses the reset when both strobes rise together. A sparse conversion enable and strobe activity in the middle of a conversion check that only the enable sets the pace.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CONV = 2'd1,
    ST_DONE = 2'd2,
    ST_CLR  = 2'd3
  } sar_state_t;
endpackage

// File: rtl/sar_sync.sv
module sar_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  // Inactive level of the active-low strobes is 1.
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] shreg;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) shreg <= '1;
      else        shreg <= {shreg[STAGES-2:0], async_i[g]};
    end
    assign sync_o[g] = shreg[STAGES-1];
  end
endmodule

// File: rtl/sar_seq.sv
module sar_seq #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_mid,
  input  logic             step,
  input  logic             cmp_above,
  output logic [WIDTH-1:0] code,
  output logic             at_lsb
);
  localparam logic [WIDTH-1:0] MID = {1'b1, {(WIDTH-1){1'b0}}};

  logic [WIDTH-1:0] code_q;
  logic [WIDTH-1:0] ptr_q;   // one-hot marker of the bit under trial

  // Decide the current bit, then raise the next lower one.
  function automatic logic [WIDTH-1:0] next_trial(
    input logic [WIDTH-1:0] cur,
    input logic [WIDTH-1:0] ptr,
    input logic             above
  );
    logic [WIDTH-1:0] kept;
    kept = above ? (cur & ~ptr) : cur;
    return kept | (ptr >> 1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      ptr_q  <= '0;
    end else if (load_mid) begin
      code_q <= MID;
      ptr_q  <= MID;
    end else if (step) begin
      code_q <= next_trial(code_q, ptr_q, cmp_above);
      ptr_q  <= ptr_q >> 1;
    end
  end

  assign code   = code_q;
  assign at_lsb = ptr_q[0];

  AST_MID_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load_mid |=> (code_q == MID)); // R7

  AST_STEP_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load_mid) |=> (((code_q ^ $past(code_q)) &
      ~($past(ptr_q) | ($past(ptr_q) >> 1))) == '0)); // R3
endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl
  import sar_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cs_lo,
  input  logic rd_rise,
  input  logic conv_en,
  input  logic at_lsb,
  output logic load_mid,
  output logic step,
  output logic busy_n,
  output logic done
);
  sar_state_t state_q, state_d;

  always_comb begin
    state_d  = state_q;
    load_mid = 1'b0;
    step     = 1'b0;
    unique case (state_q)
      ST_DONE: if (rd_rise) state_d = ST_CLR;
      ST_CLR: begin
        if (conv_en) begin
          load_mid = 1'b1;
          state_d  = ST_IDLE;
        end
      end
      ST_IDLE: if (cs_lo) state_d = ST_CONV;
      ST_CONV: begin
        if (conv_en) begin
          step = 1'b1;
          if (at_lsb) state_d = ST_DONE;
        end
      end
      default: state_d = ST_DONE;
    endcase
  end

  // Power-up lands in the finished state: a dummy read re-arms it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_DONE;
    else        state_q <= state_d;
  end

  assign busy_n = (state_q != ST_CONV);
  assign done   = (state_q == ST_DONE);

  AST_DONE_AFTER_LSB: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_n) |-> $past(at_lsb && conv_en)); // R4

  AST_CONV_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_n && !(at_lsb && conv_en)) |=> !busy_n); // R5

  AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_n) |-> ($past(state_q) == ST_IDLE && $past(cs_lo))); // R2
endmodule

// File: rtl/sar_bus_ctrl.sv
module sar_bus_ctrl #(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             rd_n,
  input  logic             conv_en,
  input  logic             cmp_above,
  output logic [WIDTH-1:0] trial_code,
  output logic             busy_n,
  output logic [WIDTH-1:0] data_o,
  output logic             data_oe
);
  logic [1:0] strobe_s;
  logic       cs_n_s, rd_n_s;
  logic       cs_n_d, rd_n_d;
  logic       rd_rise;
  logic       load_mid, step, at_lsb, done;

  sar_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({cs_n, rd_n}),
    .sync_o  (strobe_s)
  );
  assign cs_n_s = strobe_s[1];
  assign rd_n_s = strobe_s[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n_d <= 1'b1;
      rd_n_d <= 1'b1;
    end else begin
      cs_n_d <= cs_n_s;
      rd_n_d <= rd_n_s;
    end
  end

  // Read released while select was low in the previous cycle; this also
  // catches both strobes rising together.
  assign rd_rise = rd_n_s && !rd_n_d && !cs_n_d;

  sar_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_lo    (!cs_n_s),
    .rd_rise  (rd_rise),
    .conv_en  (conv_en),
    .at_lsb   (at_lsb),
    .load_mid (load_mid),
    .step     (step),
    .busy_n   (busy_n),
    .done     (done)
  );

  sar_seq #(.WIDTH(WIDTH)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_mid  (load_mid),
    .step      (step),
    .cmp_above (cmp_above),
    .code      (trial_code),
    .at_lsb    (at_lsb)
  );

  assign data_oe = !cs_n_s && !rd_n_s && done;
  assign data_o  = data_oe ? trial_code : '0;

  AST_OE_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> busy_n); // R6
endmodule

// File: tb/tb_sar_bus_ctrl.sv
`timescale 1ns/1ps
module tb_sar_bus_ctrl;
  localparam int W = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, cs_n, rd_n, sparse, conv_en;
  logic [W-1:0] ain;
  logic [W-1:0] trial_code, data_o;
  logic busy_n, data_oe;
  logic cmp_above;
  int   en_cnt = 0;
  int   n_tests = 0, n_fail = 0;
  bit   finished = 0;

  always @(posedge clk) en_cnt <= (en_cnt == 2) ? 0 : en_cnt + 1;
  always_comb conv_en = sparse ? (en_cnt == 0) : 1'b1;
  always_comb cmp_above = (trial_code > ain);

  sar_bus_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n),
    .conv_en(conv_en), .cmp_above(cmp_above), .trial_code(trial_code),
    .busy_n(busy_n), .data_o(data_o), .data_oe(data_oe)
  );

  // {input code, expected result}
  localparam logic [15:0] VEC [8] = '{16'h0000, 16'hFFFF, 16'h8080, 16'h7F7F,
                                      16'h0101, 16'hAAAA, 16'h5555, 16'hC8C8};

  function automatic logic [W-1:0] model(input logic [W-1:0] x);
    logic [W-1:0] r = '0;
    for (int b = W - 1; b >= 0; b--) begin
      logic [W-1:0] t = r | (W'(1) << b);
      if (!(t > x)) r = t;
    end
    return r;
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_ready(input string req, input int limit);
    int n = 0;
    while (busy_n !== 1'b1 && n < limit) begin tick(1); n++; end
    chk(req, int'(busy_n), 1);
  endtask

  // Read while cs_n low; release rd_n then cs_n one cycle later.
  task automatic ram_read(input string req, input logic [W-1:0] exp);
    cs_n = 0; rd_n = 0; tick(3);
    chk({req, " oe"}, int'(data_oe), 1);
    chk({req, " data"}, int'(data_o), int'(exp));
    rd_n = 1; tick(1); cs_n = 1; tick(6);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; cs_n = 1; rd_n = 1; sparse = 0; ain = '0;
    tick(4); rst_n = 1; tick(2);
    chk("R1 busy", int'(busy_n), 1);
    chk("R1 oe", int'(data_oe), 0);
    // R1: power-up dummy read, R7: re-arm to mid code
    ram_read("R1 dummy", 8'h00);
    chk("R7 mid code", int'(trial_code), 8'h80);
    chk("R7 idle busy", int'(busy_n), 1);

    // R3: table walk, write-then-read access
    foreach (VEC[i]) begin
      ain = VEC[i][15:8];
      cs_n = 0; rd_n = 1; tick(3);
      chk("R2 write start", int'(busy_n), 0);
      cs_n = 1;
      wait_ready("R4 ready", 30);
      tick(1);
      chk("R6 oe with cs high", int'(data_oe), 0);
      ram_read("R3 result", VEC[i][7:0]);
    end

    // R4 + R5: exact length with cs_n toggled mid-conversion
    ain = 8'h3C;
    cs_n = 0; tick(5); cs_n = 1; tick(2); cs_n = 0; tick(3);
    chk("R4 still busy at edge 10", int'(busy_n), 0);
    tick(1);
    chk("R4 ready at edge 11", int'(busy_n), 1);
    // R9: cs low, rd high in finished state
    tick(10);
    chk("R9 no restart", int'(busy_n), 1);
    rd_n = 0; tick(3);
    chk("R5 result", int'(data_o), int'(model(ain)));
    rd_n = 1; tick(1); cs_n = 1; tick(6);

    // R10: read during conversion
    ain = 8'h6B;
    cs_n = 0; rd_n = 1; tick(4);
    rd_n = 0; tick(3);
    chk("R10 oe while busy", int'(data_oe), 0);
    chk("R10 data while busy", int'(data_o), 0);
    rd_n = 1;
    wait_ready("R10 ready", 30);
    cs_n = 1; tick(3);
    ram_read("R10 result", model(8'h6B));

    // R7: rd pulse with cs high keeps result
    ain = 8'hD2;
    cs_n = 0; tick(3); cs_n = 1;
    wait_ready("R7 ready", 30);
    rd_n = 0; tick(3); rd_n = 1; tick(4);
    chk("R7 no reset busy", int'(busy_n), 1);
    ram_read("R7 kept", model(8'hD2));

    // R8: chip select tied low, read restarts
    ain = 8'h3C;
    cs_n = 0; tick(3);
    wait_ready("R8 first", 30);
    rd_n = 0; tick(3);
    chk("R8 first data", int'(data_o), 8'h3C);
    ain = 8'hE1;
    rd_n = 1; tick(6);
    chk("R8 auto restart", int'(busy_n), 0);
    wait_ready("R8 second", 30);
    rd_n = 0; tick(3);
    chk("R8 second data", int'(data_o), int'(model(8'hE1)));
    rd_n = 1; tick(1); cs_n = 1; tick(8);
    chk("R8 no restart after deselect", int'(busy_n), 1);

    // R4: sparse enable stretches the conversion
    sparse = 1; ain = 8'h96;
    cs_n = 0; tick(3); cs_n = 1; tick(17);
    chk("R4 sparse still busy", int'(busy_n), 0);
    wait_ready("R4 sparse ready", 60);
    ram_read("R4 sparse data", model(8'h96));
    tick(6);
    sparse = 0;

    // R2: strobes tied together (wait-state host)
    ain = 8'h47;
    cs_n = 0; rd_n = 0; tick(3);
    chk("R2 joint start", int'(busy_n), 0);
    chk("R10 joint oe", int'(data_oe), 0);
    wait_ready("R2 joint ready", 30);
    chk("R6 joint oe", int'(data_oe), 1);
    chk("R3 joint data", int'(data_o), int'(model(8'h47)));
    cs_n = 1; rd_n = 1; tick(8);
    chk("R7 joint reset code", int'(trial_code), 8'h80);
    chk("R7 joint idle", int'(busy_n), 1);
    chk("R6 joint oe off", int'(data_oe), 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule